// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer Controller

This block keeps the transmit and receive buffers of one endpoint. Each direction owns two halves that are used in turn: one half is filled while the other, once marked valid, waits to be read. Every half has its own byte count and read position. The USB side always reads from the oldest valid half. On the transmit side, the DMA engine fills the halves and the USB side sends them. On the receive side, the USB side fills the halves and the DMA engine reads them.

Software controls the buffers through an 8-bit command code with a strobe. The commands are: mark the transmit fill half valid, drop the oldest transmit half, rewind all read positions, and return the block to its power-on state. The same command path also records whether a DMA transfer is running and whether a stop command may end it. A one-cycle "sent" pulse from the serial side releases the oldest transmit half without software.

Top module: `ep_pingpong_buf`

## Requirements
- R1: After reset, no half is valid, every count and read position is 0, both fill and oldest selectors point at half 0, each direction reports empty=1 and full=0, and xferActive is 0.
- R2: A write stores its byte at the current count of the fill half and raises that count by one. The write is ignored when the fill half is valid or when its count already equals DEPTH.
- R3: Command 0x0E (transmit) or an rxDone pulse (receive) marks the fill half valid and moves fill to the other half. It does this only if the fill half is not valid and holds at least one byte; otherwise it has no effect.
- R4: rdData shows the byte at the read position of the oldest valid half, or 0 when no valid half has an unread byte. A read strobe advances that position only while unread bytes remain.
- R5: Command 0x0F frees exactly the oldest valid transmit half: its valid flag, count and read position go to 0 and the oldest selector toggles. A second 0x0F frees the other half. With nothing valid, 0x0F has no effect, and it never changes the receive side.
- R6: A txSent pulse frees the oldest valid transmit half in the same way as 0x0F.
- R7: Command 0x10 sets every read position in both directions to 0 and sets the count of every half that is not valid to 0. Valid flags, selectors and stored bytes are kept.
- R8: On the receive side, the read that consumes the last byte of the oldest half frees that half and toggles the oldest selector.
- R9: Command 0x11 returns both directions and the transfer state to the reset values of R1.
- R10: Commands 0x06/0x07 start a stoppable transfer and 0x00/0x01 start a non-stoppable one, each setting xferActive=1. Command 0x12 clears xferActive only when the running transfer is stoppable. Other codes leave the transfer state alone.
- R11: Within a direction, 0x11 takes priority over 0x10, then free, then validate. When any of these is present, that cycle's write and read strobes for the direction are ignored. txSent together with 0x0F frees only one half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 8 | Command code |
| txWrEn | input | 1 | DMA writes a byte into the transmit fill half |
| txWrData | input | DW | Transmit write byte |
| txRdEn | input | 1 | USB side reads a transmit byte |
| txSent | input | 1 | Oldest transmit half has gone out on USB |
| txRdData | output | DW | Transmit byte at the read position |
| txValid | output | 2 | Valid flag per transmit half |
| txCount | output | 2*CW | Byte count per transmit half |
| txRdPos | output | CW | Read position of the oldest transmit half |
| txFillSel | output | 1 | Transmit half being filled |
| txOldSel | output | 1 | Oldest transmit half |
| txFull | output | 1 | Both transmit halves valid |
| txEmpty | output | 1 | No transmit half valid |
| rxWrEn | input | 1 | USB side writes a byte into the receive fill half |
| rxWrData | input | DW | Receive write byte |
| rxDone | input | 1 | Receive packet complete, validate fill half |
| rxRdEn | input | 1 | DMA reads a receive byte |
| rxRdData | output | DW | Receive byte at the read position |
| rxValid | output | 2 | Valid flag per receive half |
| rxCount | output | 2*CW | Byte count per receive half |
| rxRdPos | output | CW | Read position of the oldest receive half |
| rxFillSel | output | 1 | Receive half being filled |
| rxOldSel | output | 1 | Oldest receive half |
| rxFull | output | 1 | Both receive halves valid |
| rxEmpty | output | 1 | No receive half valid |
| xferActive | output | 1 | A DMA transfer is running |

## Verification
The bench builds the block with DEPTH=4 and DW=8. Because a half fills after four writes, the full-half write drop, the state with both halves valid, and the single-half free while the other half stays valid can all be reached in a few cycles. With halves this small, a long random run with colliding commands, sends and data strobes passes through every selector combination many times, and the behavioural model is compared on each of those cycles.

// File: rtl/ep_pingpong_pkg.sv
package ep_pingpong_pkg;
  localparam logic [7:0] CMD_GEN_IN    = 8'h00;
  localparam logic [7:0] CMD_GEN_OUT   = 8'h01;
  localparam logic [7:0] CMD_MW_IN     = 8'h06;
  localparam logic [7:0] CMD_MW_OUT    = 8'h07;
  localparam logic [7:0] CMD_VALIDATE  = 8'h0E;
  localparam logic [7:0] CMD_CLEAR     = 8'h0F;
  localparam logic [7:0] CMD_RESTART   = 8'h10;
  localparam logic [7:0] CMD_DMA_RESET = 8'h11;
  localparam logic [7:0] CMD_MW_STOP   = 8'h12;

  typedef struct packed {
    logic dmaReset;
    logic restart;
    logic txValidate;
    logic txClear;
  } bufStrobe_t;
endpackage

// File: rtl/ep_cmd_ctrl.sv
module ep_cmd_ctrl
  import ep_pingpong_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  output bufStrobe_t strb,
  output logic       xferActive
);
  logic active;
  logic multi;

  always_comb begin
    strb.dmaReset   = cmdValid && (cmdCode == CMD_DMA_RESET);
    strb.restart    = cmdValid && (cmdCode == CMD_RESTART);
    strb.txValidate = cmdValid && (cmdCode == CMD_VALIDATE);
    strb.txClear    = cmdValid && (cmdCode == CMD_CLEAR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      multi  <= 1'b0;
    end else if (cmdValid) begin
      case (cmdCode)
        CMD_GEN_IN, CMD_GEN_OUT: begin
          active <= 1'b1;
          multi  <= 1'b0;
        end
        CMD_MW_IN, CMD_MW_OUT: begin
          active <= 1'b1;
          multi  <= 1'b1;
        end
        CMD_MW_STOP: begin
          if (multi) begin
            active <= 1'b0;
            multi  <= 1'b0;
          end
        end
        CMD_DMA_RESET: begin
          active <= 1'b0;
          multi  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign xferActive = active;

  // R10: a stop leaves a non-stoppable transfer running
  a_r10_stop_generic_kept: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_MW_STOP && !multi) |=> (xferActive == $past(xferActive)));

  // R9: the reset command always leaves the transfer idle
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.dmaReset |=> !xferActive);
endmodule

// File: rtl/ep_pingpong_pair.sv
module ep_pingpong_pair #(
  parameter int DW = 8,
  parameter int DEPTH = 8,
  parameter bit FREE_ON_LAST_READ = 1'b0,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                doReset,
  input  logic                doRestart,
  input  logic                doFree,
  input  logic                doValidate,
  input  logic                wrEn,
  input  logic [DW-1:0]       wrData,
  input  logic                rdEn,
  output logic [DW-1:0]       rdData,
  output logic [1:0]          valid,
  output logic [1:0][CW-1:0]  count,
  output logic [CW-1:0]       rdPos,
  output logic                fillSel,
  output logic                oldSel,
  output logic                full,
  output logic                empty
);
  logic [DW-1:0]      mem [2][DEPTH];
  logic [1:0][CW-1:0] cnt;
  logic [CW-1:0]      rdPtr [2];
  logic [1:0]         vld;
  logic               fill;
  logic               old;

  logic ctrl, canWr, canRd, lastRd;

  assign ctrl   = doReset || doRestart || doFree || doValidate;
  assign canWr  = !ctrl && wrEn && !vld[fill] && (cnt[fill] < CW'(DEPTH));
  assign canRd  = !ctrl && rdEn && vld[old] && (rdPtr[old] < cnt[old]);
  assign lastRd = FREE_ON_LAST_READ && canRd && ((rdPtr[old] + CW'(1)) == cnt[old]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld  <= '0;
      fill <= 1'b0;
      old  <= 1'b0;
      for (int h = 0; h < 2; h++) begin
        cnt[h]   <= '0;
        rdPtr[h] <= '0;
      end
    end else if (doReset) begin
      vld  <= '0;
      fill <= 1'b0;
      old  <= 1'b0;
      for (int h = 0; h < 2; h++) begin
        cnt[h]   <= '0;
        rdPtr[h] <= '0;
      end
    end else if (doRestart) begin
      for (int h = 0; h < 2; h++) begin
        rdPtr[h] <= '0;
        if (!vld[h]) cnt[h] <= '0;
      end
    end else if (doFree) begin
      if (vld[old]) begin
        vld[old]   <= 1'b0;
        cnt[old]   <= '0;
        rdPtr[old] <= '0;
        old        <= !old;
      end
    end else if (doValidate) begin
      if (!vld[fill] && cnt[fill] != '0) begin
        vld[fill] <= 1'b1;
        fill      <= !fill;
      end
    end else begin
      if (canWr) cnt[fill] <= cnt[fill] + CW'(1);
      if (lastRd) begin
        vld[old]   <= 1'b0;
        cnt[old]   <= '0;
        rdPtr[old] <= '0;
        old        <= !old;
      end else if (canRd) begin
        rdPtr[old] <= rdPtr[old] + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (canWr) mem[fill][AW'(cnt[fill])] <= wrData;
  end

  assign rdData  = (vld[old] && rdPtr[old] < cnt[old]) ? mem[old][AW'(rdPtr[old])] : '0;
  assign valid   = vld;
  assign count   = cnt;
  assign rdPos   = rdPtr[old];
  assign fillSel = fill;
  assign oldSel  = old;
  assign full    = vld[0] && vld[1];
  assign empty   = !vld[0] && !vld[1];

  // R2: no half holds more than DEPTH bytes
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[0] <= CW'(DEPTH)) && (cnt[1] <= CW'(DEPTH)));

  // R3: a valid half is never empty
  a_r3_valid_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    (!vld[0] || cnt[0] != '0) && (!vld[1] || cnt[1] != '0));

  // R4: the read position never passes the count
  a_r4_read_bounded: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr[old] <= cnt[old]);

  // R5: a free with a valid half releases exactly one half
  a_r5_free_one_half: assert property (@(posedge clk) disable iff (!rstN)
    (doFree && !doReset && !doRestart && vld[old]) |=>
      ($countones(vld) + 1 == $past($countones(vld))));

  // R7: restart keeps every valid flag
  a_r7_restart_keeps_valid: assert property (@(posedge clk) disable iff (!rstN)
    (doRestart && !doReset) |=> (vld == $past(vld)));

  // R11: a control cycle never adds data to any half
  a_r11_ctrl_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    ctrl |=> ((cnt[0] <= $past(cnt[0])) && (cnt[1] <= $past(cnt[1]))));
endmodule

// File: rtl/ep_pingpong_buf.sv
module ep_pingpong_buf
  import ep_pingpong_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [7:0]          cmdCode,
  input  logic                txWrEn,
  input  logic [DW-1:0]       txWrData,
  input  logic                txRdEn,
  input  logic                txSent,
  output logic [DW-1:0]       txRdData,
  output logic [1:0]          txValid,
  output logic [1:0][CW-1:0]  txCount,
  output logic [CW-1:0]       txRdPos,
  output logic                txFillSel,
  output logic                txOldSel,
  output logic                txFull,
  output logic                txEmpty,
  input  logic                rxWrEn,
  input  logic [DW-1:0]       rxWrData,
  input  logic                rxDone,
  input  logic                rxRdEn,
  output logic [DW-1:0]       rxRdData,
  output logic [1:0]          rxValid,
  output logic [1:0][CW-1:0]  rxCount,
  output logic [CW-1:0]       rxRdPos,
  output logic                rxFillSel,
  output logic                rxOldSel,
  output logic                rxFull,
  output logic                rxEmpty,
  output logic                xferActive
);
  bufStrobe_t strb;

  ep_cmd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .strb(strb), .xferActive(xferActive)
  );

  ep_pingpong_pair #(.DW(DW), .DEPTH(DEPTH), .FREE_ON_LAST_READ(1'b0)) uTx (
    .clk(clk), .rstN(rstN),
    .doReset(strb.dmaReset), .doRestart(strb.restart),
    .doFree(strb.txClear || txSent), .doValidate(strb.txValidate),
    .wrEn(txWrEn), .wrData(txWrData), .rdEn(txRdEn), .rdData(txRdData),
    .valid(txValid), .count(txCount), .rdPos(txRdPos),
    .fillSel(txFillSel), .oldSel(txOldSel), .full(txFull), .empty(txEmpty)
  );

  ep_pingpong_pair #(.DW(DW), .DEPTH(DEPTH), .FREE_ON_LAST_READ(1'b1)) uRx (
    .clk(clk), .rstN(rstN),
    .doReset(strb.dmaReset), .doRestart(strb.restart),
    .doFree(1'b0), .doValidate(rxDone),
    .wrEn(rxWrEn), .wrData(rxWrData), .rdEn(rxRdEn), .rdData(rxRdData),
    .valid(rxValid), .count(rxCount), .rdPos(rxRdPos),
    .fillSel(rxFillSel), .oldSel(rxOldSel), .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: tb/ep_pingpong_buf_test.sv
module ep_pingpong_buf_test;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, cmdValid, txWrEn, txRdEn, txSent, rxWrEn, rxDone, rxRdEn;
  logic [7:0] cmdCode;
  logic [DW-1:0] txWrData, rxWrData, txRdData, rxRdData;
  logic [1:0] txValid, rxValid;
  logic [1:0][CW-1:0] txCount, rxCount;
  logic [CW-1:0] txRdPos, rxRdPos;
  logic txFillSel, txOldSel, txFull, txEmpty;
  logic rxFillSel, rxOldSel, rxFull, rxEmpty, xferActive;

  ep_pingpong_buf #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .txWrEn(txWrEn), .txWrData(txWrData), .txRdEn(txRdEn), .txSent(txSent),
    .txRdData(txRdData), .txValid(txValid), .txCount(txCount), .txRdPos(txRdPos),
    .txFillSel(txFillSel), .txOldSel(txOldSel), .txFull(txFull), .txEmpty(txEmpty),
    .rxWrEn(rxWrEn), .rxWrData(rxWrData), .rxDone(rxDone), .rxRdEn(rxRdEn),
    .rxRdData(rxRdData), .rxValid(rxValid), .rxCount(rxCount), .rxRdPos(rxRdPos),
    .rxFillSel(rxFillSel), .rxOldSel(rxOldSel), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .xferActive(xferActive)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference: [direction][half]
  int mMem [2][2][DEPTH];
  int mCnt [2][2];
  int mRd  [2][2];
  bit mV   [2][2];
  int mFill [2];
  int mOld  [2];
  bit mAct, mMulti;
  bit cRs, cRt, cVa, cCl;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic mClearDir(int d);
    for (int h = 0; h < 2; h++) begin
      mCnt[d][h] = 0; mRd[d][h] = 0; mV[d][h] = 0;
    end
    mFill[d] = 0; mOld[d] = 0;
  endtask

  task automatic mFreeOld(int d);
    int o;
    o = mOld[d];
    mV[d][o] = 0; mCnt[d][o] = 0; mRd[d][o] = 0;
    mOld[d] = 1 - o;
  endtask

  task automatic mDir(int d, bit rs, bit rt, bit fr, bit va, bit we, int wd, bit re);
    int f, o;
    f = mFill[d];
    o = mOld[d];
    if (rs) mClearDir(d);
    else if (rt) begin
      for (int h = 0; h < 2; h++) begin
        mRd[d][h] = 0;
        if (!mV[d][h]) mCnt[d][h] = 0;
      end
    end else if (fr) begin
      if (mV[d][o]) mFreeOld(d);
    end else if (va) begin
      if (!mV[d][f] && mCnt[d][f] > 0) begin
        mV[d][f] = 1;
        mFill[d] = 1 - f;
      end
    end else begin
      if (we && !mV[d][f] && mCnt[d][f] < DEPTH) begin
        mMem[d][f][mCnt[d][f]] = wd;
        mCnt[d][f]++;
      end
      if (re && mV[d][o] && mRd[d][o] < mCnt[d][o]) begin
        mRd[d][o]++;
        if (d == 1 && mRd[d][o] == mCnt[d][o]) mFreeOld(d);
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mClearDir(0); mClearDir(1); mAct = 0; mMulti = 0;
    end else begin
      cRs = cmdValid && cmdCode == 8'h11;
      cRt = cmdValid && cmdCode == 8'h10;
      cVa = cmdValid && cmdCode == 8'h0E;
      cCl = cmdValid && cmdCode == 8'h0F;
      mDir(0, cRs, cRt, cCl || txSent, cVa, txWrEn, int'(txWrData), txRdEn);
      mDir(1, cRs, cRt, 1'b0, rxDone, rxWrEn, int'(rxWrData), rxRdEn);
      if (cmdValid) begin
        case (cmdCode)
          8'h00, 8'h01: begin mAct = 1; mMulti = 0; end
          8'h06, 8'h07: begin mAct = 1; mMulti = 1; end
          8'h12: if (mMulti) begin mAct = 0; mMulti = 0; end
          8'h11: begin mAct = 0; mMulti = 0; end
          default: ;
        endcase
      end
    end
  end

  function automatic int expData(int d);
    int o;
    o = mOld[d];
    if (mV[d][o] && mRd[d][o] < mCnt[d][o]) return mMem[d][o][mRd[d][o]];
    return 0;
  endfunction

  task automatic compareAll(string tag);
    chk(tag, "txValid0", int'(txValid[0]), int'(mV[0][0]));
    chk(tag, "txValid1", int'(txValid[1]), int'(mV[0][1]));
    chk(tag, "txCount0", int'(txCount[0]), mCnt[0][0]);
    chk(tag, "txCount1", int'(txCount[1]), mCnt[0][1]);
    chk(tag, "txRdPos", int'(txRdPos), mRd[0][mOld[0]]);
    chk(tag, "txFillSel", int'(txFillSel), mFill[0]);
    chk(tag, "txOldSel", int'(txOldSel), mOld[0]);
    chk(tag, "txFull", int'(txFull), int'(mV[0][0] && mV[0][1]));
    chk(tag, "txEmpty", int'(txEmpty), int'(!mV[0][0] && !mV[0][1]));
    chk(tag, "txRdData", int'(txRdData), expData(0));
    chk(tag, "rxValid0", int'(rxValid[0]), int'(mV[1][0]));
    chk(tag, "rxValid1", int'(rxValid[1]), int'(mV[1][1]));
    chk(tag, "rxCount0", int'(rxCount[0]), mCnt[1][0]);
    chk(tag, "rxCount1", int'(rxCount[1]), mCnt[1][1]);
    chk(tag, "rxRdPos", int'(rxRdPos), mRd[1][mOld[1]]);
    chk(tag, "rxFillSel", int'(rxFillSel), mFill[1]);
    chk(tag, "rxOldSel", int'(rxOldSel), mOld[1]);
    chk(tag, "rxFull", int'(rxFull), int'(mV[1][0] && mV[1][1]));
    chk(tag, "rxEmpty", int'(rxEmpty), int'(!mV[1][0] && !mV[1][1]));
    chk(tag, "rxRdData", int'(rxRdData), expData(1));
    chk(tag, "xferActive", int'(xferActive), int'(mAct));
  endtask

  task automatic idle();
    cmdValid = 0; cmdCode = 8'h00;
    txWrEn = 0; txRdEn = 0; txSent = 0;
    rxWrEn = 0; rxDone = 0; rxRdEn = 0;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
    idle();
  endtask

  task automatic cmd(logic [7:0] code, string tag);
    cmdValid = 1; cmdCode = code; tick(tag);
  endtask

  task automatic txWr(int v, string tag);
    txWrEn = 1; txWrData = DW'(v); tick(tag);
  endtask

  task automatic rxWr(int v, string tag);
    rxWrEn = 1; rxWrData = DW'(v); tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(); txWrData = 0; rxWrData = 0;
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    compareAll("R1");
    chk("R1", "txEmpty literal", int'(txEmpty), 1);
    chk("R1", "rxFull literal", int'(rxFull), 0);

    // R2: fill half 0, fifth write dropped
    for (int i = 0; i < 5; i++) txWr(8'h10 + i, "R2");
    chk("R2", "txCount0 literal", int'(txCount[0]), DEPTH);
    // R3: validate, then second half, then validate with an empty fill half
    cmd(8'h0E, "R3");
    for (int i = 0; i < 3; i++) txWr(8'h20 + i, "R2");
    cmd(8'h0E, "R3");
    chk("R3", "txFull literal", int'(txFull), 1);
    txWr(8'h99, "R2");
    cmd(8'h0E, "R3");
    // R4: read oldest half in order
    chk("R4", "txRdData first", int'(txRdData), 8'h10);
    txRdEn = 1; tick("R4");
    txRdEn = 1; tick("R4");
    chk("R4", "txRdData third", int'(txRdData), 8'h12);
    // R7: restart rewinds without dropping data
    cmd(8'h10, "R7");
    chk("R7", "txRdData rewound", int'(txRdData), 8'h10);
    // RX data present before TX clears
    for (int i = 0; i < 2; i++) rxWr(8'h40 + i, "R5");
    rxDone = 1; tick("R3");
    // R5: two clears, then clear on empty
    cmd(8'h0F, "R5");
    chk("R5", "txRdData second half", int'(txRdData), 8'h20);
    cmd(8'h0F, "R5");
    chk("R5", "txEmpty literal", int'(txEmpty), 1);
    cmd(8'h0F, "R5");
    // R6: txSent frees
    txWr(8'h31, "R6"); cmd(8'h0E, "R6");
    txSent = 1; tick("R6");
    // R11: sent and clear together free one half; write with a command ignored
    txWr(8'h51, "R11"); cmd(8'h0E, "R11");
    txWr(8'h52, "R11"); cmd(8'h0E, "R11");
    txSent = 1; cmdValid = 1; cmdCode = 8'h0F; tick("R11");
    chk("R11", "one half left", int'(txValid[0]) + int'(txValid[1]), 1);
    txWrEn = 1; txWrData = 8'h77; cmdValid = 1; cmdCode = 8'h10; tick("R11");
    txWrEn = 1; txWrData = 8'h78; cmdValid = 1; cmdCode = 8'h0E; tick("R11");
    // R7: restart drops a partial fill but keeps valid halves
    txWr(8'h61, "R7"); cmd(8'h10, "R7");
    // R8: receive read of last byte frees half
    rxRdEn = 1; tick("R8");
    rxRdEn = 1; tick("R8");
    chk("R8", "rxEmpty literal", int'(rxEmpty), 1);
    // R10: transfer tracking
    cmd(8'h06, "R10");
    chk("R10", "mw active", int'(xferActive), 1);
    cmd(8'h12, "R10");
    chk("R10", "mw stopped", int'(xferActive), 0);
    cmd(8'h00, "R10");
    cmd(8'h12, "R10");
    chk("R10", "generic kept", int'(xferActive), 1);
    cmd(8'h05, "R10");
    // R9: reset command clears everything
    rxWr(8'h70, "R9"); txWr(8'h71, "R9"); cmd(8'h0E, "R9");
    cmd(8'h11, "R9");
    chk("R9", "txEmpty literal", int'(txEmpty), 1);
    chk("R9", "xferActive literal", int'(xferActive), 0);
    // random collisions against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 18) begin
        cmdValid = 1;
        case ($urandom_range(0, 8))
          0: cmdCode = 8'h0E; 1: cmdCode = 8'h0E; 2: cmdCode = 8'h0F;
          3: cmdCode = 8'h10; 4: cmdCode = 8'h12; 5: cmdCode = 8'h06;
          6: cmdCode = 8'h00; 7: cmdCode = 8'h05;
          default: cmdCode = ($urandom_range(0, 9) == 0) ? 8'h11 : 8'h07;
        endcase
      end
      txWrEn = ($urandom_range(0, 1) == 1); txWrData = DW'($urandom);
      txRdEn = ($urandom_range(0, 2) == 0);
      txSent = ($urandom_range(0, 9) == 0);
      rxWrEn = ($urandom_range(0, 1) == 1); rxWrData = DW'($urandom);
      rxRdEn = ($urandom_range(0, 2) == 0);
      rxDone = ($urandom_range(0, 5) == 0);
      tick("R11");
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule